// File: doc/BRIEF.md
# Frame-Locked Bit-Clock Divider

The block divides a 7680 kHz reference clock by a nominal 40 to produce a 192 kHz bit-rate enable. The divider is not fixed. When an external frame strobe arrives, the block reads the position of the bit-phase counter at that instant. It then stretches or trims the next bit period by one reference cycle (1/40 of a bit) so that bit boundaries drift onto the strobe. Corrections are rate-limited to one per 250 µs window. The frame strobe runs at 8 kHz on the network side and at 4 kHz on the terminal side. An input selects which rate applies, and that rate sets how long the block waits before it declares the strobe lost.

A second enable marks the receive sampling instant. It is the transmit enable delayed by a programmable number of reference cycles, so it carries every correction open-loop and has no tracking of its own. A bit counter and a lock flag complete the outputs. Both enables are single-cycle pulses in the reference domain, and no derived clock leaves the block.

The lock supervisor is a state machine with three states. FREE is the reset state and the state after a strobe loss. ACQ means strobes are present but lock is not yet earned. LOCK means lock is held. Its transitions are: FREE→ACQ on any strobe; FREE→LOCK or ACQ→LOCK on the fourth consecutive on-phase strobe; LOCK→ACQ on the second consecutive off-phase strobe; ACQ→FREE or LOCK→FREE on strobe timeout.

Top module: `bitclk_dpll`

## Requirements
- R1: After reset the phase counter is 0, so `tx_bit_en` is high in the first cycle. `bit_cnt` is 0, `locked` is 0, and the supervisor is in FREE.
- R2: With no correction pending, `tx_bit_en` pulses exactly every 40 reference cycles.
- R3: A strobe seen at phase 0 schedules no correction. A strobe at phase 1..19 makes the next bit period 41 cycles long. A strobe at phase 20 or later makes it 39 cycles long. Only the period that starts after the current one is altered.
- R4: A correction is scheduled only if at least 1920 reference cycles have passed since the previous scheduled correction. Strobes inside that window are still classified but schedule nothing.
- R5: `rate_sel` = 0 selects the 8 kHz frame rate (period 960 cycles). `rate_sel` = 1 selects 4 kHz (period 1920 cycles).
- R6: `locked` rises in the cycle after the 4th consecutive strobe at phase 0. It falls in the cycle after the 2nd consecutive strobe off phase 0.
- R7: `rx_smp_en` equals `tx_bit_en` delayed by `rx_ofs` cycles. Values of 40 or more act as 39.
- R8: When no strobe has arrived for two full frame periods of the selected rate, the supervisor enters FREE and `locked` drops. Any pending correction is discarded, and the divider runs at 40.
- R9: `bit_cnt` increments by one at every bit start and wraps at 256.
- R10: `tx_bit_en` and `rx_smp_en` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 7680 kHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | Single-cycle frame strobe, 8 kHz or 4 kHz |
| rate_sel | input | 1 | 0: 8 kHz frame rate, 1: 4 kHz frame rate |
| rx_ofs | input | 6 | Receive sampling delay in reference cycles (clamped to 39) |
| tx_bit_en | output | 1 | Transmit bit-start pulse |
| rx_smp_en | output | 1 | Receive sampling pulse |
| bit_cnt | output | 8 | Index of the current bit, wrapping |
| locked | output | 1 | Bit clock locked to the frame strobe |

## Verification
The embedded properties assume that `frame_stb` is a one-cycle pulse and that strobes are much further apart than a bit period. They also assume that `rx_ofs` does not change while a delayed pulse is still in flight, because otherwise a moved tap could emit two receive pulses back to back. The stimulus drives each strobe for exactly one cycle and spaces strobes hundreds of cycles apart. It changes `rx_ofs` only with long idle stretches between changes, and it aims each strobe at a chosen phase so that early, late and on-phase arrivals are all produced on purpose. Rate switching is done only while strobes are absent, so the timeout threshold never moves under a running gap count that is near its limit.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_LOCK = 2'd2
    } lock_st_e;

    typedef enum logic [1:0] {
        CORR_NONE  = 2'd0,
        CORR_LONG  = 2'd1,
        CORR_SHORT = 2'd2
    } corr_e;

endpackage

// File: rtl/dpll_phase_ctr.sv
module dpll_phase_ctr
    import dpll_pkg::*;
#(
    parameter int DIV_NOM = 40,
    parameter int WIN_CYC = 1920,
    parameter int BIT_W   = 8
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             drop_pend,
    output logic             phase_zero,
    output logic [BIT_W-1:0] bit_cnt
);
    localparam int PH_W  = $clog2(DIV_NOM + 2);
    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam logic [PH_W-1:0]  LIM_NOM   = PH_W'(DIV_NOM);
    localparam logic [PH_W-1:0]  LIM_LONG  = PH_W'(DIV_NOM + 1);
    localparam logic [PH_W-1:0]  LIM_SHORT = PH_W'(DIV_NOM - 1);
    localparam logic [PH_W-1:0]  HALF      = PH_W'(DIV_NOM / 2);
    localparam logic [WIN_W-1:0] WIN_FULL  = WIN_W'(WIN_CYC);

    logic [PH_W-1:0]  ph_q, lim_q, lim_nx;
    logic [WIN_W-1:0] since_q;
    logic [BIT_W-1:0] bit_q;
    corr_e            pend_q, pend_nx;
    logic             wrap, sched;

    always_comb begin
        wrap  = (ph_q == lim_q - 1'b1);
        sched = frame_stb && (ph_q != '0) && (since_q == WIN_FULL);
        unique case (pend_q)
            CORR_LONG:  lim_nx = LIM_LONG;
            CORR_SHORT: lim_nx = LIM_SHORT;
            default:    lim_nx = LIM_NOM;
        endcase
        pend_nx = pend_q;
        if (drop_pend)
            pend_nx = CORR_NONE;
        else if (sched)
            pend_nx = (ph_q < HALF) ? CORR_LONG : CORR_SHORT;
        else if (wrap)
            pend_nx = CORR_NONE;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            ph_q    <= '0;
            lim_q   <= LIM_NOM;
            pend_q  <= CORR_NONE;
            since_q <= WIN_FULL;
            bit_q   <= '0;
        end else begin
            pend_q <= pend_nx;
            if (wrap) begin
                ph_q  <= '0;
                lim_q <= lim_nx;
                bit_q <= bit_q + 1'b1;
            end else begin
                ph_q <= ph_q + 1'b1;
            end
            if (sched)
                since_q <= '0;
            else if (since_q != WIN_FULL)
                since_q <= since_q + 1'b1;
        end
    end

    assign phase_zero = (ph_q == '0);
    assign bit_cnt    = bit_q;

    // R3
    ph_range_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ph_q <= LIM_LONG - 1'b1);

    // R3
    zero_no_corr_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (frame_stb && phase_zero) |=> (pend_q == $past(pend_q)));

    // R10
    tx_single_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        phase_zero |=> !phase_zero);

endmodule

// File: rtl/dpll_lock_fsm.sv
module dpll_lock_fsm
    import dpll_pkg::*;
#(
    parameter int FP_FAST  = 960,
    parameter int FP_SLOW  = 1920,
    parameter int LOCK_CNT = 4,
    parameter int DROP_CNT = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic phase_zero,
    input  logic rate_sel,
    output logic locked,
    output logic timeout
);
    localparam int GAP_W = $clog2(2 * FP_SLOW + 1);
    localparam int GW    = $clog2(LOCK_CNT + 1);
    localparam int BW    = $clog2(DROP_CNT + 1);
    localparam logic [GAP_W-1:0] GAP_F  = GAP_W'(2 * FP_FAST);
    localparam logic [GAP_W-1:0] GAP_S  = GAP_W'(2 * FP_SLOW);
    localparam logic [GW-1:0]    G_LAST = GW'(LOCK_CNT - 1);
    localparam logic [GW-1:0]    G_SAT  = GW'(LOCK_CNT);
    localparam logic [BW-1:0]    B_LAST = BW'(DROP_CNT - 1);
    localparam logic [BW-1:0]    B_SAT  = BW'(DROP_CNT);

    lock_st_e         state_q, state_nx;
    logic [GAP_W-1:0] gap_q;
    logic [GW-1:0]    good_q;
    logic [BW-1:0]    bad_q;
    logic             hit, miss, tmo;

    always_comb begin
        hit  = frame_stb && phase_zero;
        miss = frame_stb && !phase_zero;
        tmo  = !frame_stb && (state_q != ST_FREE) &&
               (gap_q >= (rate_sel ? GAP_S : GAP_F));
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (hit && good_q == G_LAST) state_nx = ST_LOCK;
                else if (frame_stb)          state_nx = ST_ACQ;
            end
            ST_ACQ: begin
                if (tmo)                          state_nx = ST_FREE;
                else if (hit && good_q == G_LAST) state_nx = ST_LOCK;
            end
            ST_LOCK: begin
                if (tmo)                          state_nx = ST_FREE;
                else if (miss && bad_q == B_LAST) state_nx = ST_ACQ;
            end
            default: state_nx = ST_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            good_q <= '0;
            bad_q  <= '0;
        end else begin
            if (frame_stb)         gap_q <= '0;
            else if (gap_q != GAP_S) gap_q <= gap_q + 1'b1;
            if (tmo) begin
                good_q <= '0;
                bad_q  <= '0;
            end else if (hit) begin
                bad_q  <= '0;
                if (good_q != G_SAT) good_q <= good_q + 1'b1;
            end else if (miss) begin
                good_q <= '0;
                if (bad_q != B_SAT) bad_q <= bad_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        locked  = (state_q == ST_LOCK);
        timeout = tmo;
    end

    // R6
    lock_cause_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(locked) |-> $past(hit));

    // R8
    loss_unlock_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        timeout |=> !locked);

endmodule

// File: rtl/dpll_rx_tap.sv
module dpll_rx_tap #(
    parameter int DIV_NOM = 40,
    parameter int OFS_W   = $clog2(DIV_NOM)
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             tx_bit_en,
    input  logic [OFS_W-1:0] rx_ofs,
    output logic             rx_smp_en
);
    localparam logic [OFS_W-1:0] OFS_MAX = OFS_W'(DIV_NOM - 1);

    logic [DIV_NOM-1:0] dly_q;
    logic [OFS_W-1:0]   ofs_c;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) dly_q[0] <= 1'b0;
        else        dly_q[0] <= tx_bit_en;
    end

    for (genvar i = 1; i < DIV_NOM; i++) begin : g_tap
        always_ff @(posedge clk_ref or negedge rst_n) begin
            if (!rst_n) dly_q[i] <= 1'b0;
            else        dly_q[i] <= dly_q[i-1];
        end
    end

    always_comb begin
        ofs_c     = (rx_ofs > OFS_MAX) ? OFS_MAX : rx_ofs;
        rx_smp_en = (ofs_c == '0) ? tx_bit_en : dly_q[ofs_c - 1'b1];
    end

    // R10
    rx_single_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (rx_smp_en && $stable(rx_ofs)) |=> !rx_smp_en);

endmodule

// File: rtl/bitclk_dpll.sv
module bitclk_dpll
    import dpll_pkg::*;
#(
    parameter int DIV_NOM  = 40,
    parameter int WIN_CYC  = 1920,
    parameter int FP_FAST  = 960,
    parameter int FP_SLOW  = 1920,
    parameter int BIT_W    = 8,
    localparam int OFS_W   = $clog2(DIV_NOM)
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             rate_sel,
    input  logic [OFS_W-1:0] rx_ofs,
    output logic             tx_bit_en,
    output logic             rx_smp_en,
    output logic [BIT_W-1:0] bit_cnt,
    output logic             locked
);
    logic phase_zero, timeout;

    dpll_phase_ctr #(.DIV_NOM(DIV_NOM), .WIN_CYC(WIN_CYC), .BIT_W(BIT_W)) u_ph (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .drop_pend  (timeout),
        .phase_zero (phase_zero),
        .bit_cnt    (bit_cnt)
    );

    dpll_lock_fsm #(.FP_FAST(FP_FAST), .FP_SLOW(FP_SLOW)) u_fsm (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .phase_zero (phase_zero),
        .rate_sel   (rate_sel),
        .locked     (locked),
        .timeout    (timeout)
    );

    assign tx_bit_en = phase_zero;

    dpll_rx_tap #(.DIV_NOM(DIV_NOM), .OFS_W(OFS_W)) u_rx (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .tx_bit_en (tx_bit_en),
        .rx_ofs    (rx_ofs),
        .rx_smp_en (rx_smp_en)
    );

endmodule

// File: tb/sim_bitclk_dpll.sv
`timescale 1ns/1ps
module sim_bitclk_dpll;
    logic       clk = 1'b0;
    logic       rst_n, frame_stb, rate_sel;
    logic [5:0] rx_ofs;
    logic       tx_bit_en, rx_smp_en, locked;
    logic [7:0] bit_cnt;

    always #2 clk = ~clk;

    bitclk_dpll u0 (
        .clk_ref(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rate_sel(rate_sel),
        .rx_ofs(rx_ofs), .tx_bit_en(tx_bit_en), .rx_smp_en(rx_smp_en),
        .bit_cnt(bit_cnt), .locked(locked)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    // behavioural model state
    int m_ph, m_lim, m_pend, m_since, m_gap, m_state, m_good, m_bad, m_bit;
    bit m_hist[$];
    // measurements taken from the ports
    int last_tx = -1, seen41 = 0, seen39 = 0, rx_delta = -1;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_lim = 40; m_pend = 0; m_since = 1920; m_gap = 0;
        m_state = 0; m_good = 0; m_bad = 0; m_bit = 0;
        m_hist.delete();
        repeat (40) m_hist.push_back(1'b0);
    endtask

    function automatic int ofs_eff();
        return (rx_ofs > 39) ? 39 : int'(rx_ofs);
    endfunction

    task automatic model_step(bit s);
        int  fp2;
        bit  hit, miss, wrap, sched, tmo;
        fp2   = rate_sel ? 3840 : 1920;
        hit   = s && (m_ph == 0);
        miss  = s && (m_ph != 0);
        wrap  = (m_ph == m_lim - 1);
        sched = miss && (m_since >= 1920);
        tmo   = !s && (m_state != 0) && (m_gap >= fp2);
        m_hist.push_front(m_ph == 0);
        void'(m_hist.pop_back());
        if (wrap) begin
            m_lim = 40 + m_pend;
            m_pend = 0;
        end
        if (sched) m_pend = (m_ph < 20) ? 1 : -1;
        if (tmo) m_pend = 0;
        m_since = sched ? 0 : ((m_since >= 1920) ? 1920 : m_since + 1);
        m_gap   = s ? 0 : ((m_gap >= 3840) ? 3840 : m_gap + 1);
        if (tmo) begin
            m_state = 0; m_good = 0; m_bad = 0;
        end else if (hit) begin
            m_bad = 0;
            m_good = (m_good >= 4) ? 4 : m_good + 1;
            if (m_good == 4) m_state = 2;
            else if (m_state == 0) m_state = 1;
        end else if (miss) begin
            m_good = 0;
            m_bad = (m_bad >= 2) ? 2 : m_bad + 1;
            if (m_state == 0) m_state = 1;
            else if (m_state == 2 && m_bad == 2) m_state = 1;
        end
        if (wrap) begin
            m_ph = 0;
            m_bit = (m_bit + 1) % 256;
        end else begin
            m_ph = m_ph + 1;
        end
    endtask

    // compare at the falling edge, then drive inputs and advance the model
    task automatic tick(bit s);
        bit exp_tx, exp_rx;
        exp_tx = (m_ph == 0);
        exp_rx = (ofs_eff() == 0) ? exp_tx : m_hist[ofs_eff() - 1];
        chk("R2 tx_bit_en", int'(tx_bit_en), int'(exp_tx));
        chk("R7 rx_smp_en", int'(rx_smp_en), int'(exp_rx));
        chk("R9 bit_cnt", int'(bit_cnt), m_bit);
        chk("R6 locked", int'(locked), (m_state == 2) ? 1 : 0);
        if (tx_bit_en) begin
            if (last_tx >= 0) begin
                if (cyc - last_tx == 41) seen41++;
                if (cyc - last_tx == 39) seen39++;
            end
            last_tx = cyc;
        end
        if (rx_smp_en && last_tx >= 0) rx_delta = cyc - last_tx;
        frame_stb = s;
        model_step(s);
        cyc++;
        @(negedge clk);
    endtask

    // strobe once the counter sits at phase k, after at least gap idle cycles
    task automatic stb_at(int k, int gap);
        repeat (gap) tick(1'b0);
        while (m_ph != k) tick(1'b0);
        tick(1'b1);
    endtask

    initial begin
        rst_n = 1'b0; frame_stb = 1'b0; rate_sel = 1'b0; rx_ofs = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 tx_bit_en after reset", int'(tx_bit_en), 1);
        chk("R1 locked after reset", int'(locked), 0);
        chk("R1 bit_cnt after reset", int'(bit_cnt), 0);

        // R2, R9 free run
        repeat (200) tick(1'b0);
        chk("R2 no corrected period", seen41 + seen39, 0);
        chk("R9 bit count after 200 cycles", int'(bit_cnt), 5);

        // R6 acquisition
        repeat (3) stb_at(0, 950);
        chk("R6 not locked after 3 hits", int'(locked), 0);
        stb_at(0, 950);
        chk("R6 locked after 4 hits", int'(locked), 1);

        // R3 early strobe lengthens
        seen41 = 0;
        stb_at(5, 900);
        repeat (100) tick(1'b0);
        chk("R3 one 41-cycle period", seen41, 1);
        chk("R6 single miss keeps lock", int'(locked), 1);

        // R4 late strobe inside the window is not applied
        seen39 = 0;
        stb_at(30, 700);
        repeat (100) tick(1'b0);
        chk("R4 no correction inside window", seen39, 0);
        chk("R6 two misses drop lock", int'(locked), 0);

        // R3 late strobe after the window shortens
        stb_at(30, 1200);
        repeat (100) tick(1'b0);
        chk("R3 one 39-cycle period", seen39, 1);

        // R7 receive offset and clamp
        rx_ofs = 6'd13;
        repeat (100) tick(1'b0);
        chk("R7 rx delay 13", rx_delta, 13);
        rx_ofs = 6'd50;
        repeat (100) tick(1'b0);
        chk("R7 rx delay clamped", rx_delta, 39);

        // R8 strobe loss at 8 kHz
        repeat (4) stb_at(0, 950);
        chk("R6 relock", int'(locked), 1);
        repeat (1900) tick(1'b0);
        chk("R8 lock held before timeout", int'(locked), 1);
        repeat (100) tick(1'b0);
        chk("R8 lock lost after timeout", int'(locked), 0);

        // R5 4 kHz rate doubles the timeout
        rate_sel = 1'b1;
        repeat (4) stb_at(0, 1900);
        chk("R5 locked at 4 kHz", int'(locked), 1);
        repeat (3000) tick(1'b0);
        chk("R5 lock held at 4 kHz gap", int'(locked), 1);
        repeat (1000) tick(1'b0);
        chk("R5 lock lost at 4 kHz", int'(locked), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule